// File: doc/BRIEF.md
# Masked Latching Interrupt Status Controller

This block gathers one-cycle event pulses from internal resources into a bank of sticky status registers and drives one active-low interrupt line to a host. Every status bit has a matching enable bit in a mask register. An event is recorded only if its enable bit is set at the time it arrives. A disabled event is dropped and is not remembered.

The interrupt output is low while any status bit in any register is set. The host services an interrupt by reading the status registers. A read returns the register's contents and clears the register in the same cycle. An event that arrives in the same cycle as that read is kept for the next read. Mask registers are written and read at their own addresses. Reading a mask register has no side effect.

Top module: `irq_latch_ctrl`

## Requirements
- R1: When `evt_i[8*k+j]` pulses while bit j of mask register k is 1, status bit j of register k is set at that clock edge, and `irq_n` is 0 from that same edge on.
- R2: An event whose mask bit is 0 is discarded. It does not change `irq_n`, it does not appear in a later status read, and setting the mask bit afterwards does not bring it back.
- R3: `irq_n` is registered and equals the NOR of every status bit in all registers. It stays 0 while any status register is nonzero.
- R4: A read with `addr[2]`=0 selects status register `addr[1:0]`. After the edge on which `rd_en` is 1, `rdata` holds that register's old value and the register is zero.
- R5: An enabled event for register k that arrives in the same cycle as a clearing read of register k is absent from that `rdata` and remains set in register k afterwards.
- R6: A write with `addr[2]`=1 loads `wdata` into mask register `addr[1:0]`. A read with `addr[2]`=1 returns that mask and clears no status.
- R7: After reset, all status and mask registers are 0, `rdata` is 0 and `irq_n` is 1.
- R8: Status bits are sticky and accumulate by OR. A read of one status register leaves the other status registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 32 | Event pulses, bit 8*k+j feeds register k bit j |
| wr_en | input | 1 | Mask write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Bit 2 selects mask (1) or status (0); bits 1:0 select the register |
| wdata | input | 8 | Mask write data |
| rdata | output | 8 | Read data, valid after the read edge and held until the next read |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The hardest case to reach is an enabled event that arrives in the same cycle as the clearing read of its own register. If the design gets this wrong, the event is lost. The bench first sets one bit so the read has something to return. It then drives `rd_en` and a second event bit in one cycle. It checks that `rdata` holds only the first bit, that `irq_n` stays low, and that a second read returns only the second bit. A related case is a disabled event followed by enabling its mask. The bench checks that this case leaves `irq_n` high and returns an empty read.

// File: rtl/irq_latch_pkg.sv
package irq_latch_pkg;

    // Register space selected by the top address bit
    typedef enum logic {
        SPACE_STATUS = 1'b0,
        SPACE_MASK   = 1'b1
    } space_e;

endpackage

// File: rtl/irq_latch_decode.sv
module irq_latch_decode #(
    parameter int NUM_REGS = 4,
    parameter int IDX_W    = 2
) (
    input  logic               rd_en,
    input  logic               wr_en,
    input  logic [IDX_W:0]     addr,
    output logic [NUM_REGS-1:0] rd_stat,
    output logic [NUM_REGS-1:0] wr_mask
);
    import irq_latch_pkg::*;

    space_e           space;
    logic [IDX_W-1:0] idx;

    assign space = space_e'(addr[IDX_W]);
    assign idx   = addr[IDX_W-1:0];

    for (genvar k = 0; k < NUM_REGS; k++) begin : g_sel
        localparam logic [IDX_W-1:0] K_IDX = IDX_W'(k);
        assign rd_stat[k] = rd_en && (space == SPACE_STATUS) && (idx == K_IDX);
        assign wr_mask[k] = wr_en && (space == SPACE_MASK)   && (idx == K_IDX);
    end

endmodule

// File: rtl/irq_latch_bank.sv
module irq_latch_bank #(
    parameter int REG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] evt,
    input  logic             clr,
    input  logic             wr,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] status,
    output logic [REG_W-1:0] status_nxt,
    output logic [REG_W-1:0] mask
);

    typedef struct packed {
        logic [REG_W-1:0] status;
        logic [REG_W-1:0] mask;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        // clearing read wipes old bits; same-cycle enabled events still land
        if (clr) begin
            bank_d.status = '0;
        end
        bank_d.status = bank_d.status | (evt & bank_q.mask);
        if (wr) begin
            bank_d.mask = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign status     = bank_q.status;
    assign status_nxt = bank_d.status;
    assign mask       = bank_q.mask;

endmodule

// File: rtl/irq_latch_ctrl.sv
module irq_latch_ctrl #(
    parameter int NUM_REGS = 4,
    parameter int REG_W    = 8,
    localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
    localparam int ADDR_W  = IDX_W + 1,
    localparam int EVT_W   = NUM_REGS * REG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [EVT_W-1:0]  evt_i,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    output logic              irq_n
);
    import irq_latch_pkg::*;

    typedef struct packed {
        logic [REG_W-1:0] rdata;
        logic             irq_n;
    } out_t;

    logic [NUM_REGS-1:0] rd_stat;
    logic [NUM_REGS-1:0] wr_mask;
    logic [EVT_W-1:0]    status_vec;
    logic [EVT_W-1:0]    status_nxt_vec;
    logic [EVT_W-1:0]    mask_vec;

    irq_latch_decode #(
        .NUM_REGS (NUM_REGS),
        .IDX_W    (IDX_W)
    ) u_decode (
        .rd_en   (rd_en),
        .wr_en   (wr_en),
        .addr    (addr),
        .rd_stat (rd_stat),
        .wr_mask (wr_mask)
    );

    for (genvar k = 0; k < NUM_REGS; k++) begin : g_bank
        irq_latch_bank #(
            .REG_W (REG_W)
        ) u_bank (
            .clk        (clk),
            .rst_n      (rst_n),
            .evt        (evt_i[k*REG_W +: REG_W]),
            .clr        (rd_stat[k]),
            .wr         (wr_mask[k]),
            .wdata      (wdata),
            .status     (status_vec[k*REG_W +: REG_W]),
            .status_nxt (status_nxt_vec[k*REG_W +: REG_W]),
            .mask       (mask_vec[k*REG_W +: REG_W])
        );
    end

    // read data selection from the current register contents
    logic [REG_W-1:0] rd_sel;
    logic [IDX_W-1:0] rd_idx;

    assign rd_idx = addr[IDX_W-1:0];

    always_comb begin
        rd_sel = '0;
        for (int k = 0; k < NUM_REGS; k++) begin
            if (rd_idx == IDX_W'(k)) begin
                if (space_e'(addr[IDX_W]) == SPACE_MASK) begin
                    rd_sel = mask_vec[k*REG_W +: REG_W];
                end else begin
                    rd_sel = status_vec[k*REG_W +: REG_W];
                end
            end
        end
    end

    out_t out_d, out_q;

    always_comb begin
        out_d       = out_q;
        out_d.irq_n = ~(|status_nxt_vec);
        if (rd_en) begin
            out_d.rdata = rd_sel;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '{rdata: '0, irq_n: 1'b1};
        end else begin
            out_q <= out_d;
        end
    end

    assign rdata = out_q.rdata;
    assign irq_n = out_q.irq_n;

endmodule

// File: rtl/irq_latch_ctrl_chk.sv
module irq_latch_ctrl_chk #(
    parameter int NUM_REGS = 4,
    parameter int REG_W    = 8,
    parameter int IDX_W    = 2
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [NUM_REGS*REG_W-1:0] evt_i,
    input logic                      wr_en,
    input logic                      rd_en,
    input logic [IDX_W:0]            addr,
    input logic [REG_W-1:0]          wdata,
    input logic [REG_W-1:0]          rdata,
    input logic                      irq_n,
    input logic [NUM_REGS*REG_W-1:0] status_vec,
    input logic [NUM_REGS*REG_W-1:0] mask_vec
);

    // R1: any enabled event drives the interrupt low at the next edge
    p_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (|(evt_i & mask_vec)) |=> !irq_n);

    // R3: interrupt output low whenever a status bit is held
    p_irq_nor_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|status_vec) |-> !irq_n);

    for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
        localparam logic [IDX_W:0] A_STAT = {1'b0, IDX_W'(k)};
        localparam logic [IDX_W:0] A_MASK = {1'b1, IDX_W'(k)};

        // R4: read returns old status and leaves register holding only new events
        p_read_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_en && addr == A_STAT) |=>
                (rdata == $past(status_vec[k*REG_W +: REG_W])));

        // R5: same-cycle events survive the clearing read
        p_keep_evt_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_en && addr == A_STAT) |=>
                (status_vec[k*REG_W +: REG_W] ==
                 $past(evt_i[k*REG_W +: REG_W] & mask_vec[k*REG_W +: REG_W])));

        // R6: mask write lands at its own address
        p_mask_wr_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && addr == A_MASK) |=> (mask_vec[k*REG_W +: REG_W] == $past(wdata)));

        // R2/R8: without enabled events or a clearing read the register holds
        p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (!(|(evt_i[k*REG_W +: REG_W] & mask_vec[k*REG_W +: REG_W])) &&
             !(rd_en && addr == A_STAT)) |=> $stable(status_vec[k*REG_W +: REG_W]));
    end

endmodule

bind irq_latch_ctrl irq_latch_ctrl_chk #(
    .NUM_REGS (NUM_REGS),
    .REG_W    (REG_W),
    .IDX_W    (IDX_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_i      (evt_i),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .addr       (addr),
    .wdata      (wdata),
    .rdata      (rdata),
    .irq_n      (irq_n),
    .status_vec (status_vec),
    .mask_vec   (mask_vec)
);

// File: tb/irq_latch_ctrl_test.sv
module irq_latch_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] evt_i = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        irq_n;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    irq_latch_ctrl uut (
        .clk   (clk),
        .rst_n (rst_n),
        .evt_i (evt_i),
        .wr_en (wr_en),
        .rd_en (rd_en),
        .addr  (addr),
        .wdata (wdata),
        .rdata (rdata),
        .irq_n (irq_n)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // all drives and samples happen on the falling edge
    task automatic wr_mask(int k, logic [7:0] v);
        @(negedge clk);
        wr_en = 1'b1; addr = {1'b1, 2'(k)}; wdata = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, logic [31:0] ev, output logic [7:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a; evt_i = ev;
        @(negedge clk);
        rd_en = 1'b0; evt_i = '0;
        d = rdata;
    endtask

    task automatic pulse(logic [31:0] ev);
        @(negedge clk);
        evt_i = ev;
        @(negedge clk);
        evt_i = '0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        chk("R7 irq_n after reset", 32'(irq_n), 32'd1);
        chk("R7 rdata after reset", 32'(rdata), 32'd0);
        for (int k = 0; k < 4; k++) begin
            rd({1'b0, 2'(k)}, '0, d);
            chk("R7 status zero", 32'(d), 32'd0);
            rd({1'b1, 2'(k)}, '0, d);
            chk("R7 mask zero", 32'(d), 32'd0);
        end
    endtask

    task automatic t_capture();
        logic [7:0] d;
        wr_mask(0, 8'hFF);
        pulse(32'h0000_0008);
        chk("R1 irq_n low after enabled event", 32'(irq_n), 32'd0);
        rd(3'b000, '0, d);
        chk("R4 status0 read value", 32'(d), 32'h08);
        chk("R3 irq_n high once all clear", 32'(irq_n), 32'd1);
        rd(3'b000, '0, d);
        chk("R4 status0 cleared by read", 32'(d), 32'h00);
    endtask

    task automatic t_masked();
        logic [7:0] d;
        wr_mask(1, 8'h0F);
        pulse(32'h0000_F000);
        chk("R2 disabled event leaves irq_n high", 32'(irq_n), 32'd1);
        wr_mask(1, 8'hFF);
        @(negedge clk);
        chk("R2 enabling mask later raises nothing", 32'(irq_n), 32'd1);
        rd(3'b001, '0, d);
        chk("R2 discarded event not recorded", 32'(d), 32'h00);
        rd(3'b101, '0, d);
        chk("R6 mask1 readback", 32'(d), 32'hFF);
    endtask

    task automatic t_sticky();
        logic [7:0] d;
        wr_mask(2, 8'hFF);
        wr_mask(3, 8'hFF);
        pulse(32'h0001_0000);
        pulse(32'h0004_0000);
        pulse(32'h8000_0000);
        rd(3'b010, '0, d);
        chk("R8 status2 accumulates by OR", 32'(d), 32'h05);
        chk("R3 irq_n low while status3 set", 32'(irq_n), 32'd0);
        rd(3'b011, '0, d);
        chk("R8 status3 untouched by status2 read", 32'(d), 32'h80);
        chk("R3 irq_n high after last clear", 32'(irq_n), 32'd1);
    endtask

    task automatic t_collide();
        logic [7:0] d;
        pulse(32'h0000_0001);
        rd(3'b000, 32'h0000_0002, d);
        chk("R5 same-cycle event absent from rdata", 32'(d), 32'h01);
        chk("R5 irq_n stays low for kept event", 32'(irq_n), 32'd0);
        rd(3'b000, '0, d);
        chk("R5 kept event read next", 32'(d), 32'h02);
        chk("R5 irq_n high after second read", 32'(irq_n), 32'd1);
    endtask

    task automatic t_mask_read();
        logic [7:0] d;
        wr_mask(0, 8'h5A);
        pulse(32'h0000_0002);
        rd(3'b100, '0, d);
        chk("R6 mask0 readback", 32'(d), 32'h5A);
        chk("R6 mask read leaves irq_n low", 32'(irq_n), 32'd0);
        rd(3'b000, '0, d);
        chk("R6 status survives mask read", 32'(d), 32'h02);
        pulse(32'h0000_0001);
        chk("R1 bit 0 masked off by 5A", 32'(irq_n), 32'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_capture();
        t_masked();
        t_sticky();
        t_collide();
        t_mask_read();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule